// File: doc/BRIEF.md
# Port-Group Speed Map Commit Checker

This block holds the 1G/10G speed setting of every port on a line interface built from several interface engines. Each engine carries three port-groups of four ports. Software fills a staging copy of the speed map one engine slice at a time, then raises a single commit. The block checks every engine's slice against the grouping rules. If every slice is legal, the whole staged map becomes the live map in one clock edge. If any slice is illegal, the live map is left untouched and the failing engines are flagged.

A commit always ends with a one-cycle done pulse. The pulse carries an accept flag, a per-engine failure mask and, on acceptance, a mask of the ports whose speed actually changed. Downstream PHY control uses that mask so that it retrains only those ports. Speed bit value 1 means 10G and 0 means 1G. Port p belongs to engine p/12 and to group (p mod 12)/4 of that engine. Group 0 of an engine holds its lowest four ports.

Top module: `speed_map_commit`

## Requirements
- R1: After reset the live map and the staged map are all ones (every port 10G), and done, accepted, bad_engines and changed are all zero.
- R2: A commit is rejected if any group of four ports, ports 12e+4g to 12e+4g+3, holds mixed speed bits.
- R3: A commit is rejected if group 0 of an engine is 1G (all zeros) while group 1 or group 2 of that engine is 10G.
- R4: When group 0 of an engine is 10G and every group is uniform, groups 1 and 2 may each be 1G or 10G. This gives five legal engine patterns in all, counting the all-1G one.
- R5: An accepted commit replaces all ports of the live map in the same clock edge that samples commit. The new map is visible together with the done pulse.
- R6: A rejected commit leaves the live map unchanged. bad_engines bit e is set exactly when engine e breaks R2 or R3.
- R7: Each cycle with commit high produces done high in the following cycle. accepted is high only with done, and only when bad_engines is zero.
- R8: changed equals the old live map XOR the new live map in the done cycle of an accepted commit. It is zero in every other cycle, including a reject.
- R9: A write with wr_en stores wr_speed into the staged slice of engine wr_eng and has no effect on the live map or the outputs until a commit.
- R10: When wr_en and commit are high in the same cycle, the commit checks and applies the staged map as it was before that write. The write is kept for a later commit.
- R11: Engines are checked independently: a violation in one engine sets only its own bit of bad_engines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one engine slice of the staged map |
| wr_eng | input | 2 | Engine index for the write |
| wr_speed | input | 12 | Speed bits for that engine, bit 0 = lowest port |
| commit | input | 1 | Validate the staged map and apply it if legal |
| active_speed | output | 48 | Live speed map, 1 = 10G |
| done | output | 1 | One-cycle pulse ending a commit |
| accepted | output | 1 | Commit was applied (valid with done) |
| bad_engines | output | 4 | Engines that broke a rule (valid with done) |
| changed | output | 48 | Ports whose speed changed on an accepted commit |

## Verification
Several properties are checked on every cycle. The live map only moves in the done cycle of an accepted commit, and it always obeys the grouping rules. The done pulse follows a commit. The changed mask matches the real difference between the old and new live maps, and it stays zero outside accepts. Other behaviour can only be shown by the bench's scenarios. This covers which engine patterns are judged legal or illegal, whether the failure mask names the right engines, and the ordering when a write and a commit coincide.

// File: rtl/speed_map_commit.sv
module speed_map_commit #(
  parameter int ENGINES = 4,
  parameter int GROUPS = 3,
  parameter int GW = 4,
  localparam int EW = GROUPS * GW,
  localparam int NP = ENGINES * EW,
  localparam int EIW = (ENGINES > 1) ? $clog2(ENGINES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [EIW-1:0] wr_eng,
  input  logic [EW-1:0]  wr_speed,
  input  logic           commit,
  output logic [NP-1:0]  active_speed,
  output logic           done,
  output logic           accepted,
  output logic [ENGINES-1:0] bad_engines,
  output logic [NP-1:0]  changed
);

  logic [NP-1:0] staged;
  logic [ENGINES-1:0] eng_bad;

  for (genvar e = 0; e < ENGINES; e++) begin : g_eng
    logic [EW-1:0] s;
    logic [GROUPS-1:0] uni, hi;
    assign s = staged[e*EW +: EW];
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign hi[g]  = &s[g*GW +: GW];
      assign uni[g] = hi[g] | ~|s[g*GW +: GW];
    end
    assign eng_bad[e] = ~&uni | ~(hi[0] | ~|hi[GROUPS-1:1]);

    always_ff @(posedge clk) begin
      if (!rst_n) staged[e*EW +: EW] <= '1;
      else if (wr_en && wr_eng == EIW'(e)) staged[e*EW +: EW] <= wr_speed;
    end
  end

  wire ok = ~|eng_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_speed <= '1;
      done <= 1'b0;
      accepted <= 1'b0;
      bad_engines <= '0;
      changed <= '0;
    end else begin
      done <= commit;
      accepted <= commit & ok;
      bad_engines <= commit ? eng_bad : '0;
      changed <= (commit && ok) ? (active_speed ^ staged) : '0;
      if (commit && ok) active_speed <= staged;
    end
  end

  function automatic logic map_legal(input logic [NP-1:0] m);
    logic r;
    r = 1'b1;
    for (int e = 0; e < ENGINES; e++) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (m[e*EW + g*GW +: GW] != '0 && m[e*EW + g*GW +: GW] != '1) r = 1'b0;
        if (g > 0 && m[e*EW] == 1'b0 && m[e*EW + g*GW] == 1'b1) r = 1'b0;
      end
    end
    return r;
  endfunction

  // R5
  live_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_speed) |-> done && accepted);
  // R6
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !accepted |-> bad_engines != '0 && $stable(active_speed));
  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(commit));
  // R7
  accept_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |-> done && bad_engines == '0);
  // R8
  change_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && accepted) |-> changed == '0);
  // R8
  change_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && accepted |-> changed == (active_speed ^ $past(active_speed)));
  // R2
  live_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_legal(active_speed));

endmodule

// File: tb/sim_speed_map_commit.sv
module sim_speed_map_commit;
  logic clk = 0, rst_n = 0, wr_en = 0, commit = 0;
  logic [1:0] wr_eng = 0;
  logic [11:0] wr_speed = 0;
  logic [47:0] active_speed, changed;
  logic done, accepted;
  logic [3:0] bad_engines;
  int nvec = 0, nbad = 0;
  logic [47:0] model = '1;

  always #10 clk = ~clk;

  speed_map_commit u0 (.clk, .rst_n, .wr_en, .wr_eng, .wr_speed, .commit,
    .active_speed, .done, .accepted, .bad_engines, .changed);

  localparam logic [11:0] A = 12'hFFF, B = 12'h000, C = 12'h00F, D = 12'h0FF,
    E = 12'hF0F, F = 12'hFF0, G = 12'h007, H = 12'h0F0, I = 12'hF00;
  // {map (engine3..engine0), accept, bad mask}
  localparam logic [52:0] VEC [8] = '{
    {A, A, A, B, 1'b1, 4'b0000},
    {C, D, E, A, 1'b1, 4'b0000},
    {F, A, A, A, 1'b0, 4'b1000},
    {A, G, A, H, 1'b0, 4'b0101},
    {B, B, B, B, 1'b1, 4'b0000},
    {I, F, G, H, 1'b0, 4'b1111},
    {E, D, C, B, 1'b1, 4'b0000},
    {A, A, A, A, 1'b1, 4'b0000}};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int e, logic [11:0] d);
    @(negedge clk); wr_en = 1; wr_eng = 2'(e); wr_speed = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 active", 64'(active_speed), 64'(48'hFFFF_FFFF_FFFF));
    chk("R1 done", 64'({done, accepted, bad_engines}), 64'd0);
    chk("R1 changed", 64'(changed), 64'd0);
    rst_n = 1;
    // R1 staged defaults to all 10G: commit without writes changes nothing
    do_commit();
    chk("R1 staged", 64'({done, accepted, bad_engines}), 64'b110000);
    chk("R1 chg", 64'(changed), 64'd0);

    // R2 R3 R4 R5 R6 R8 R11 table walk
    for (int v = 0; v < 8; v++) begin
      logic [47:0] m;
      logic [47:0] exp_chg;
      m = VEC[v][52:5];
      for (int e = 0; e < 4; e++) wr(e, m[e*12 +: 12]);
      // R9 staged writes do not touch live map
      chk("R9 hold", 64'(active_speed), 64'(model));
      do_commit();
      exp_chg = VEC[v][4] ? (model ^ m) : '0;
      if (VEC[v][4]) model = m;
      chk("R7 done", 64'(done), 64'd1);
      chk("R2 R3 R4 accept", 64'(accepted), 64'(VEC[v][4]));
      chk("R6 R11 bad mask", 64'(bad_engines), 64'(VEC[v][3:0]));
      chk("R5 R6 live map", 64'(active_speed), 64'(model));
      chk("R8 changed", 64'(changed), 64'(exp_chg));
      @(negedge clk);
      chk("R7 pulse end", 64'({done, accepted, bad_engines}), 64'd0);
      chk("R8 idle", 64'(changed), 64'd0);
    end

    // R10 write and commit in the same cycle
    @(negedge clk); wr_en = 1; wr_eng = 0; wr_speed = B; commit = 1;
    @(negedge clk); wr_en = 0; commit = 0;
    chk("R10 old staged used", 64'(active_speed), 64'(48'hFFFF_FFFF_FFFF));
    chk("R10 no change", 64'(changed), 64'd0);
    do_commit();
    chk("R10 later commit", 64'(active_speed), 64'(48'hFFFF_FFFF_F000));
    chk("R10 changed", 64'(changed), 64'(48'h000000000FFF));

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #4000000;
    nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule